// File: doc/BRIEF.md
# Handshaked Shift-Register Packet Mover

This block carries byte packets in both directions between a host processor and the packet buffers of a microcontroller, using a single shift-data register and three active-low handshake lines on an 8-bit port register. The host drives the handshake by writing the port register. Each valid handshake step moves one byte: an inbound byte is loaded into the shift register, or the host's byte is taken from the shift register into the outbound buffer. Every step raises a shift-complete flag, which the host polls or takes as an interrupt.

The microcontroller side fills an inbound buffer of up to `IN_DEPTH` bytes and commits it with a length. The block signals pending data on the request line of the port register. Outbound bytes collect in an `OUT_DEPTH`-byte buffer. The host ends an outbound packet by clearing the shift-out bit of the auxiliary control register. The block then reports a one-cycle delivery pulse with the length and a class taken from the first byte, and the dispatcher reads the bytes through a random-access port.

Host register map (2-bit select): 0 port register, 1 shift data, 2 auxiliary control, 3 flags. Port register bits: bit 3 request (driven by the block, active low), bit 4 acknowledge, bit 5 transfer-in-progress (both active low, written by the host). Auxiliary control bit 4 = shift out. Flags bit 2 = shift complete.

Top module: `shift_pkt_xfer`

## Requirements
- R1: After reset the shift register reads 0, the flags register reads 0, the port register reads 0x38 with the request bit 3 high, `treq_n` is 1 and `pkt_valid` is 0.
- R2: A write to the port register is a handshake step only when it writes bit 5 as 0 and its bits {5,4} differ from the stored bits {5,4}. Rewriting the same value, or writing bit 5 as 1, moves no byte and leaves the shift register unchanged.
- R3: A step taken while unread inbound bytes remain loads the next inbound byte into the shift register, advances the read position, and sets the shift flag (flags bit 2).
- R4: The request line (`treq_n` and port bit 3) is 0 while unread inbound bytes remain and 1 otherwise.
- R5: Committing an inbound packet rewinds the read position to its first byte and sets the shift flag in the next cycle. A commit has priority over a step in the same cycle.
- R6: While auxiliary bit 4 is 1, a step stores the shift register value into the outbound buffer and sets the shift flag.
- R7: Outbound bytes after the first `OUT_DEPTH` are dropped, and the delivered length never exceeds `OUT_DEPTH`.
- R8: A write that changes auxiliary bit 4 from 1 to 0 ends the outbound packet. If at least one byte was stored, `pkt_valid` pulses for one cycle with `pkt_len` equal to the stored count. The outbound position then restarts at 0.
- R9: Ending an outbound packet that holds no bytes gives no `pkt_valid` pulse.
- R10: `pkt_kind` classifies the first delivered byte: 0 when it is 0x00 (bus-device packet), 1 when it is 0x01 (controller command packet), 2 for any other value.
- R11: A step with no unread inbound byte and auxiliary bit 4 at 0 loads 0 into the shift register and does not set the shift flag.
- R12: Writing 1 to flags bit 2 clears the shift flag. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register (combinational) |
| fill_wr | input | 1 | Write one byte into the inbound buffer |
| fill_idx | input | IN_AW | Inbound buffer byte position |
| fill_data | input | 8 | Inbound byte |
| fill_commit | input | 1 | Commit the inbound packet |
| fill_len | input | IN_LW | Inbound packet length at commit |
| treq_n | output | 1 | Active-low request: unread inbound bytes remain |
| shift_flag | output | 1 | Shift-complete flag |
| pkt_valid | output | 1 | One-cycle outbound delivery pulse |
| pkt_len | output | OUT_LW | Delivered outbound length |
| pkt_kind | output | 2 | Delivered packet class |
| pkt_rd_idx | input | OUT_AW | Outbound buffer read position |
| pkt_rd_data | output | 8 | Outbound byte at `pkt_rd_idx` |

## Verification
Each host write or commit takes effect at the clock edge on which it is presented. The shift register, flag, request line and delivery pulse therefore show the result one cycle later, and `pkt_valid` falls again on the edge after that. The bench presents stimulus on the falling edge, removes it on the next falling edge, and samples just after that point. So every check reads the state exactly one edge after its stimulus, and the delivery pulse is checked high there and low one cycle later. Register reads and outbound byte reads are combinational and are sampled a short delay after the select changes.

// File: rtl/shift_xfer_pkg.sv
package shift_xfer_pkg;

    typedef enum logic [1:0] {
        REG_PORT  = 2'd0,
        REG_SHIFT = 2'd1,
        REG_AUX   = 2'd2,
        REG_FLAGS = 2'd3
    } reg_sel_e;

    localparam int PORT_REQ_BIT  = 3;
    localparam int PORT_ACK_BIT  = 4;
    localparam int PORT_BUSY_BIT = 5;
    localparam int AUX_OUT_BIT   = 4;
    localparam int FLAG_SH_BIT   = 2;

    localparam logic [7:0] PORT_RESET = 8'h30;

    typedef enum logic [1:0] {
        PKT_DEVICE  = 2'd0,
        PKT_CONTROL = 2'd1,
        PKT_OTHER   = 2'd2
    } pkt_kind_e;

    function automatic pkt_kind_e classify(input logic [7:0] first);
        case (first)
            8'h00:   return PKT_DEVICE;
            8'h01:   return PKT_CONTROL;
            default: return PKT_OTHER;
        endcase
    endfunction

endpackage

// File: rtl/spx_inbound.sv
module spx_inbound #(
    parameter int DEPTH = 128
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [$clog2(DEPTH)-1:0]       wr_idx,
    input  logic [7:0]                     wr_data,
    input  logic                           commit,
    input  logic [$clog2(DEPTH+1)-1:0]     commit_len,
    input  logic                           take,
    output logic                           pending,
    output logic [7:0]                     next_byte
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [LW-1:0] rd_pos_q;
    logic [LW-1:0] size_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pos_q <= '0;
            size_q   <= '0;
        end else if (commit) begin
            rd_pos_q <= '0;
            size_q   <= (commit_len > DEPTH_L) ? DEPTH_L : commit_len;
        end else if (take && pending) begin
            rd_pos_q <= rd_pos_q + 1'b1;
        end
    end

    assign pending   = rd_pos_q < size_q;
    assign next_byte = mem[rd_pos_q[AW-1:0]];

    // R5
    commit_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> (rd_pos_q == '0));

    // R3
    take_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (take && pending && !commit) |=> (rd_pos_q == $past(rd_pos_q) + 1'b1));
endmodule

// File: rtl/spx_outbound.sv
module spx_outbound
    import shift_xfer_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         store,
    input  logic [7:0]                   din,
    input  logic                         finish,
    input  logic [$clog2(DEPTH)-1:0]     rd_idx,
    output logic [7:0]                   rd_data,
    output logic                         valid,
    output logic [$clog2(DEPTH+1)-1:0]   len,
    output pkt_kind_e                    kind
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [LW-1:0] wr_pos_q;
    logic          room;

    assign room = wr_pos_q < DEPTH_L;

    always_ff @(posedge clk) begin
        if (store && room) mem[wr_pos_q[AW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pos_q <= '0;
            valid    <= 1'b0;
            len      <= '0;
            kind     <= PKT_DEVICE;
        end else begin
            valid <= 1'b0;
            if (finish) begin
                wr_pos_q <= '0;
                if (wr_pos_q != '0) begin
                    valid <= 1'b1;
                    len   <= wr_pos_q;
                    kind  <= classify(mem[0]);
                end
            end else if (store && room) begin
                wr_pos_q <= wr_pos_q + 1'b1;
            end
        end
    end

    assign rd_data = mem[rd_idx];

    // R7
    fill_cap_chk: assert property (@(posedge clk) disable iff (rst)
        wr_pos_q <= DEPTH_L);

    // R8
    delivered_len_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> (len != '0));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        finish |=> (wr_pos_q == '0));

    // R9
    empty_end_chk: assert property (@(posedge clk) disable iff (rst)
        (finish && wr_pos_q == '0) |=> !valid);
endmodule

// File: rtl/shift_pkt_xfer.sv
module shift_pkt_xfer
    import shift_xfer_pkg::*;
#(
    parameter int IN_DEPTH  = 128,
    parameter int OUT_DEPTH = 16,
    parameter int IN_AW     = $clog2(IN_DEPTH),
    parameter int IN_LW     = $clog2(IN_DEPTH + 1),
    parameter int OUT_AW    = $clog2(OUT_DEPTH),
    parameter int OUT_LW    = $clog2(OUT_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [1:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              fill_wr,
    input  logic [IN_AW-1:0]  fill_idx,
    input  logic [7:0]        fill_data,
    input  logic              fill_commit,
    input  logic [IN_LW-1:0]  fill_len,
    output logic              treq_n,
    output logic              shift_flag,
    output logic              pkt_valid,
    output logic [OUT_LW-1:0] pkt_len,
    output logic [1:0]        pkt_kind,
    input  logic [OUT_AW-1:0] pkt_rd_idx,
    output logic [7:0]        pkt_rd_data
);
    reg_sel_e  sel;
    logic [7:0] port_q, aux_q, sr_q, sr_next;
    logic       flag_q;
    logic       wr_port, wr_aux, wr_shift, wr_flags;
    logic       step, take, out_on, store, finish;
    logic       pending, flag_set, flag_clr;
    logic [7:0] next_byte;
    pkt_kind_e  kind;

    assign sel      = reg_sel_e'(host_addr);
    assign wr_port  = host_wr && (sel == REG_PORT);
    assign wr_aux   = host_wr && (sel == REG_AUX);
    assign wr_shift = host_wr && (sel == REG_SHIFT);
    assign wr_flags = host_wr && (sel == REG_FLAGS);

    // handshake step: busy line low and the {busy, ack} pair moved
    assign step = wr_port && !host_wdata[PORT_BUSY_BIT]
               && (host_wdata[PORT_BUSY_BIT:PORT_ACK_BIT] != port_q[PORT_BUSY_BIT:PORT_ACK_BIT]);
    assign out_on = aux_q[AUX_OUT_BIT];
    assign take   = step && pending && !fill_commit;
    assign store  = step && out_on;
    assign finish = wr_aux && !host_wdata[AUX_OUT_BIT] && out_on;

    always_comb begin
        if (take)        sr_next = next_byte;
        else if (out_on) sr_next = sr_q;
        else             sr_next = 8'h00;
    end

    assign flag_set = fill_commit || take || store;
    assign flag_clr = wr_flags && host_wdata[FLAG_SH_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            port_q <= PORT_RESET;
            aux_q  <= 8'h00;
            sr_q   <= 8'h00;
            flag_q <= 1'b0;
        end else begin
            if (wr_port) port_q <= host_wdata;
            if (wr_aux)  aux_q  <= host_wdata;
            if (step)          sr_q <= sr_next;
            else if (wr_shift) sr_q <= host_wdata;
            if (flag_set)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    spx_inbound #(.DEPTH(IN_DEPTH)) u_in (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (fill_wr),
        .wr_idx     (fill_idx),
        .wr_data    (fill_data),
        .commit     (fill_commit),
        .commit_len (fill_len),
        .take       (take),
        .pending    (pending),
        .next_byte  (next_byte)
    );

    spx_outbound #(.DEPTH(OUT_DEPTH)) u_out (
        .clk     (clk),
        .rst     (rst),
        .store   (store),
        .din     (sr_next),
        .finish  (finish),
        .rd_idx  (pkt_rd_idx),
        .rd_data (pkt_rd_data),
        .valid   (pkt_valid),
        .len     (pkt_len),
        .kind    (kind)
    );

    assign pkt_kind   = kind;
    assign treq_n     = !pending;
    assign shift_flag = flag_q;

    always_comb begin
        case (sel)
            REG_PORT:  host_rdata = {port_q[7:4], treq_n, port_q[2:0]};
            REG_SHIFT: host_rdata = sr_q;
            REG_AUX:   host_rdata = aux_q;
            default:   host_rdata = {5'b0, flag_q, 2'b0};
        endcase
    end

    // R3
    inbound_load_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (sr_q == $past(next_byte)) && flag_q);

    // R4
    request_after_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_commit && fill_len != '0) |=> !treq_n);

    // R5
    commit_flag_chk: assert property (@(posedge clk) disable iff (rst)
        fill_commit |=> shift_flag);

    // R2
    busy_high_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_port && host_wdata[PORT_BUSY_BIT]) |=> $stable(sr_q));

    // R12
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !flag_set) |=> !shift_flag);
endmodule

// File: tb/shift_pkt_xfer_tb.sv
`timescale 1ns/1ps
module shift_pkt_xfer_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr;
    logic [1:0] host_addr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       fill_wr;
    logic [6:0] fill_idx;
    logic [7:0] fill_data;
    logic       fill_commit;
    logic [7:0] fill_len;
    logic       treq_n;
    logic       shift_flag;
    logic       pkt_valid;
    logic [4:0] pkt_len;
    logic [1:0] pkt_kind;
    logic [3:0] pkt_rd_idx;
    logic [7:0] pkt_rd_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] cur_port = 8'h30;

    always #2.5 clk = ~clk;

    shift_pkt_xfer u_dut (
        .clk(clk), .rst(rst),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fill_wr(fill_wr), .fill_idx(fill_idx), .fill_data(fill_data),
        .fill_commit(fill_commit), .fill_len(fill_len),
        .treq_n(treq_n), .shift_flag(shift_flag),
        .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_kind(pkt_kind),
        .pkt_rd_idx(pkt_rd_idx), .pkt_rd_data(pkt_rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        if (a == 2'd0) cur_port = d;
    endtask

    task automatic hread(input logic [1:0] a, output logic [7:0] d);
        host_addr = a;
        #0.5;
        d = host_rdata;
    endtask

    task automatic pread(input int i, output logic [7:0] d);
        pkt_rd_idx = 4'(i);
        #0.5;
        d = pkt_rd_data;
    endtask

    // one handshake step: busy low, ack toggled
    task automatic hs_step();
        hwrite(2'd0, cur_port[4] ? 8'h00 : 8'h10);
    endtask

    task automatic fill_pkt(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fill_wr = 1'b1; fill_idx = 7'(i);
            fill_data = (i == 0) ? b0 : (i == 1) ? b1 : b2;
        end
        @(negedge clk);
        fill_wr = 1'b0; fill_commit = 1'b1; fill_len = 8'(n);
        @(negedge clk);
        fill_commit = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        hread(2'd1, v); chk("R1 shift", v, 8'h00);
        hread(2'd3, v); chk("R1 flags", v, 8'h00);
        hread(2'd0, v); chk("R1 port", v, 8'h38);
        chk("R1 treq_n", treq_n, 1);
        chk("R1 pkt_valid", pkt_valid, 0);
    endtask

    task automatic t_inbound();
        logic [7:0] v;
        fill_pkt(8'h00, 8'hA5, 8'h3C, 3);
        chk("R5 flag at commit", shift_flag, 1);
        chk("R4 request low", treq_n, 0);
        hread(2'd0, v); chk("R4 port bit3", v[3], 0);
        hwrite(2'd3, 8'h04);
        hread(2'd3, v); chk("R12 flag cleared", v, 8'h00);
        hs_step();
        hread(2'd1, v); chk("R3 byte0", v, 8'h00);
        chk("R3 flag", shift_flag, 1);
        hs_step();
        hread(2'd1, v); chk("R3 byte1", v, 8'hA5);
        hwrite(2'd0, cur_port);
        hread(2'd1, v); chk("R2 same value no step", v, 8'hA5);
        chk("R4 still pending", treq_n, 0);
        hwrite(2'd0, 8'h20);
        hread(2'd1, v); chk("R2 busy high no step", v, 8'hA5);
        chk("R2 busy high keeps pending", treq_n, 0);
        hs_step();
        hread(2'd1, v); chk("R3 byte2", v, 8'h3C);
        chk("R4 request high when drained", treq_n, 1);
        hread(2'd0, v); chk("R4 port bit3 high", v[3], 1);
        hwrite(2'd3, 8'h04);
        hs_step();
        hread(2'd1, v); chk("R11 empty step loads zero", v, 8'h00);
        chk("R11 no flag", shift_flag, 0);
    endtask

    task automatic t_rewind();
        logic [7:0] v;
        fill_pkt(8'h11, 8'h22, 8'h00, 2);
        hs_step();
        hread(2'd1, v); chk("R3 first of A", v, 8'h11);
        fill_pkt(8'h77, 8'h88, 8'h00, 2);
        hs_step();
        hread(2'd1, v); chk("R5 rewound to first", v, 8'h77);
        hs_step();
        chk("R4 drained", treq_n, 1);
    endtask

    task automatic t_outbound();
        logic [7:0] v;
        hwrite(2'd2, 8'h10);
        hwrite(2'd3, 8'h04);
        hwrite(2'd1, 8'h01); hs_step();
        chk("R6 flag on store", shift_flag, 1);
        hwrite(2'd1, 8'h0B); hs_step();
        hwrite(2'd1, 8'h77); hs_step();
        chk("R8 no pulse before end", pkt_valid, 0);
        hwrite(2'd2, 8'h00);
        chk("R8 pulse", pkt_valid, 1);
        chk("R8 len", pkt_len, 3);
        chk("R10 control kind", pkt_kind, 1);
        pread(0, v); chk("R6 byte0", v, 8'h01);
        pread(1, v); chk("R6 byte1", v, 8'h0B);
        pread(2, v); chk("R6 byte2", v, 8'h77);
        @(negedge clk);
        chk("R8 pulse one cycle", pkt_valid, 0);
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        hwrite(2'd2, 8'h10);
        for (int i = 0; i < 20; i++) begin
            hwrite(2'd1, 8'(i)); hs_step();
        end
        hwrite(2'd2, 8'h00);
        chk("R7 pulse", pkt_valid, 1);
        chk("R7 len capped", pkt_len, 16);
        chk("R10 device kind", pkt_kind, 0);
        pread(15, v); chk("R7 last kept byte", v, 8'h0F);
        pread(3, v);  chk("R7 early byte", v, 8'h03);
        // restart after delivery: a fresh one-byte packet
        hwrite(2'd2, 8'h10);
        hwrite(2'd1, 8'h05); hs_step();
        hwrite(2'd2, 8'h00);
        chk("R8 restart len", pkt_len, 1);
        chk("R10 other kind", pkt_kind, 2);
    endtask

    task automatic t_empty();
        hwrite(2'd2, 8'h10);
        hwrite(2'd2, 8'h00);
        chk("R9 no pulse", pkt_valid, 0);
        @(negedge clk);
        chk("R9 still no pulse", pkt_valid, 0);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        hwrite(2'd3, 8'h04);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 2'd3; host_wdata = 8'h04;
        fill_commit = 1'b1; fill_len = 8'd0;
        @(negedge clk);
        host_wr = 1'b0; fill_commit = 1'b0;
        hread(2'd3, v); chk("R12 set wins", v, 8'h04);
        hwrite(2'd3, 8'h04);
        hread(2'd3, v); chk("R12 clear", v, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; host_wr = 1'b0; host_addr = 2'd0; host_wdata = 8'h00;
        fill_wr = 1'b0; fill_idx = '0; fill_data = '0; fill_commit = 1'b0; fill_len = '0;
        pkt_rd_idx = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_inbound();
        t_rewind();
        t_outbound();
        t_overflow();
        t_empty();
        t_set_wins();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule